// File: doc/BRIEF.md
# Two-Bit Not-Recently-Used Victim Selector

This block picks which line of a small group of cache lines should be evicted next. Each line has two usage flags: a recent flag and a very-recent flag. Every access sets both flags of the accessed line. Both flag sets are wiped at regular intervals, measured in counted accesses. The very-recent flags are wiped more often than the recent flags, so the two flags together give a coarse record of how long ago each line was last touched.

When the cache needs to make room, it raises a replace request. On that clock edge the block picks the lowest-numbered line that has neither flag set. If there is none, it picks the lowest-numbered line that has only the recent flag set. If there is still none, it takes a pseudo-random line from a free-running 8-bit LFSR. The chosen index is registered and held until the next request. Tag storage and the data path belong to the surrounding cache.

Top module: `nru_victim_sel`

## Requirements
- R1: While `rst` is high, all flags and both access counters are cleared, `victim_idx` is 0, and the LFSR is loaded with 8'h01.
- R2: When `acc_valid` is high, both flags of line `acc_idx` are set at that clock edge.
- R3: On every VRU_PERIOD-th accepted access counted from reset (default 16), all very-recent flags are cleared in that same edge. The recent flags are not cleared by this event.
- R4: On every RU_PERIOD-th accepted access counted from reset (default 64), all recent flags are cleared in that same edge.
- R5: If an access falls on a clearing edge, the clear is applied first, so the accessed line ends that edge with both flags set.
- R6: On an edge where `repl_req` is high, if any line has both flags clear, `victim_idx` takes the lowest such index. The new value is visible after that edge.
- R7: Otherwise, if any line has the recent flag set and the very-recent flag clear, `victim_idx` takes the lowest such index.
- R8: Otherwise, `victim_idx` takes the LFSR value modulo NUM_LINES. The LFSR advances on every edge out of reset, with next = {q[6:0], q[7]^q[5]^q[4]^q[3]}.
- R9: `victim_idx` does not change on edges where `repl_req` is low.
- R10: When an access and a replace request fall on the same edge, the choice uses the flag state from before that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A line was accessed this cycle |
| acc_idx | input | $clog2(NUM_LINES) | Index of the accessed line |
| repl_req | input | 1 | Request a victim choice this cycle |
| victim_idx | output | $clog2(NUM_LINES) | Registered victim line index |

## Verification
The assertions assume that `acc_idx` always names an existing line, and that RU_PERIOD is larger than VRU_PERIOD. Under those assumptions, exactly one very-recent flag survives a clearing access. The default line count of eight uses every encoding of `acc_idx`, so the stimulus cannot reach a line that does not exist. Both wipe events are reached by counting accesses up to their periods. Random picks are compared with a model of the LFSR polynomial that is kept in the bench and runs from the same reset.

// File: rtl/nru_pkg.sv
package nru_pkg;
  localparam int LFSR_W = 8;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 8'h01;

  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] q);
    return {q[6:0], q[7] ^ q[5] ^ q[4] ^ q[3]};
  endfunction
endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr
  import nru_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] lfsr_q
);
  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_SEED;
    else     lfsr_q <= lfsr_next(lfsr_q);
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0); // R8
endmodule

// File: rtl/nru_usage_bits.sv
module nru_usage_bits #(
  parameter int NUM_LINES  = 8,
  parameter int VRU_PERIOD = 16,
  parameter int RU_PERIOD  = 64,
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int VCNT_W = $clog2(VRU_PERIOD),
  localparam int RCNT_W = $clog2(RU_PERIOD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acc_valid,
  input  logic [IDX_W-1:0]     acc_idx,
  output logic [NUM_LINES-1:0] ru_q,
  output logic [NUM_LINES-1:0] vru_q
);
  logic [VCNT_W-1:0]    vcnt_q;
  logic [RCNT_W-1:0]    rcnt_q;
  logic                 vwrap, rwrap;
  logic [NUM_LINES-1:0] ru_d, vru_d;

  assign vwrap = (vcnt_q == VCNT_W'(VRU_PERIOD - 1));
  assign rwrap = (rcnt_q == RCNT_W'(RU_PERIOD - 1));

  // clear first, then the access sets its line
  always_comb begin
    ru_d  = ru_q;
    vru_d = vru_q;
    if (acc_valid) begin
      if (vwrap) vru_d = '0;
      if (rwrap) ru_d  = '0;
      vru_d[acc_idx] = 1'b1;
      ru_d[acc_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ru_q   <= '0;
      vru_q  <= '0;
      vcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      ru_q  <= ru_d;
      vru_q <= vru_d;
      if (acc_valid) begin
        vcnt_q <= vwrap ? '0 : vcnt_q + 1'b1;
        rcnt_q <= rwrap ? '0 : rcnt_q + 1'b1;
      end
    end
  end

  AST_ACC_SETS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> (ru_q[$past(acc_idx)] && vru_q[$past(acc_idx)])); // R2
  AST_VRU_WIPE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && vwrap) |=> ($countones(vru_q) == 1)); // R3
  AST_RU_WIPE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && rwrap) |=> ($countones(ru_q) == 1)); // R4
endmodule

// File: rtl/nru_lowest_pick.sv
module nru_lowest_pick #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] mask,
  output logic                 found,
  output logic [IDX_W-1:0]     idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end
  assign found = |mask;
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
  import nru_pkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int VRU_PERIOD = 16,
  parameter int RU_PERIOD  = 64,
  localparam int IDX_W = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             repl_req,
  output logic [IDX_W-1:0] victim_idx
);
  localparam int NCLS = 2;

  logic [NUM_LINES-1:0] ru_q, vru_q;
  logic [LFSR_W-1:0]    lfsr_q;
  logic [NUM_LINES-1:0] cls_mask [NCLS];
  logic                 cls_found [NCLS];
  logic [IDX_W-1:0]     cls_idx [NCLS];
  logic [IDX_W-1:0]     rand_idx, pick;

  nru_usage_bits #(
    .NUM_LINES(NUM_LINES), .VRU_PERIOD(VRU_PERIOD), .RU_PERIOD(RU_PERIOD)
  ) u_bits (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .ru_q(ru_q), .vru_q(vru_q)
  );

  nru_lfsr u_lfsr (.clk(clk), .rst(rst), .lfsr_q(lfsr_q));

  assign cls_mask[0] = ~ru_q & ~vru_q;  // neither flag
  assign cls_mask[1] =  ru_q & ~vru_q;  // only the recent flag

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    nru_lowest_pick #(.NUM_LINES(NUM_LINES)) u_pick (
      .mask(cls_mask[c]), .found(cls_found[c]), .idx(cls_idx[c])
    );
  end

  assign rand_idx = IDX_W'(lfsr_q % NUM_LINES);

  always_comb begin
    if (cls_found[0])      pick = cls_idx[0];
    else if (cls_found[1]) pick = cls_idx[1];
    else                   pick = rand_idx;
  end

  always_ff @(posedge clk) begin
    if (rst)           victim_idx <= '0;
    else if (repl_req) victim_idx <= pick;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !repl_req |=> $stable(victim_idx)); // R9
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (rst)
    (repl_req && (ru_q == '0) && (vru_q == '0)) |=> (victim_idx == '0)); // R6
endmodule

// File: tb/nru_victim_sel_tb.sv
module nru_victim_sel_tb;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_idx = '0;
  logic       repl_req = 1'b0;
  logic [2:0] victim_idx;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  logic [7:0] m;

  always #4 clk = ~clk;

  nru_victim_sel #(.NUM_LINES(N), .VRU_PERIOD(16), .RU_PERIOD(64)) u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .repl_req(repl_req), .victim_idx(victim_idx)
  );

  // LFSR model written from the R8 polynomial
  always @(posedge clk) begin
    if (rst) m <= 8'h01;
    else     m <= {m[6:0], m[7] ^ m[5] ^ m[4] ^ m[3]};
  end

  // row: [8] access, [7:5] line, [4] replace, [3] check, [2:0] expected
  localparam int NV = 21;
  localparam logic [8:0] VEC [NV] = '{
    9'h018,                                  // R6 empty group -> 0
    9'h100, 9'h120, 9'h160,                  // access 0,1,3
    9'h01A,                                  // R2 R6 -> 2
    9'h140, 9'h180, 9'h1A0, 9'h1C0, 9'h1E0,  // access 2,4,5,6,7 (8 total)
    9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100, 9'h100, // 9..15
    9'h120,                                  // 16th access: very-recent wipe
    9'h018,                                  // R3 R7 -> 0
    9'h100,                                  // 17th access
    9'h01A                                   // R7 -> 2
  };

  task automatic check(input logic [2:0] exp, input string req);
    n_chk++;
    if (victim_idx !== exp) begin
      n_fail++;
      $display("FAIL %s: victim_idx=%0d expected %0d", req, victim_idx, exp);
    end
  endtask

  task automatic step(input logic a, input logic [2:0] ai, input logic r);
    @(negedge clk);
    acc_valid = a; acc_idx = ai; repl_req = r;
    @(negedge clk);
    acc_valid = 1'b0; repl_req = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    logic [2:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(3'd0, "R1 reset value");
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8], VEC[i][7:5], VEC[i][4]);
      if (VEC[i][3]) check(VEC[i][2:0], $sformatf("R2 R3 R6 R7 row %0d", i));
    end

    for (int k = 2; k < 8; k++) step(1'b1, 3'(k), 1'b0);  // accesses 18..23
    for (int k = 0; k < 4; k++) begin                    // R8 random picks
      @(negedge clk);
      repl_req = 1'b1; e = m[2:0];
      @(negedge clk);
      repl_req = 1'b0;
      check(e, "R8 random pick");
    end

    for (int k = 0; k < 40; k++) step(1'b1, 3'd7, 1'b0); // accesses 24..63
    step(1'b1, 3'd0, 1'b0);                              // 64th: both wiped
    step(1'b0, 3'd0, 1'b1);
    check(3'd1, "R4 R5 after recent wipe");
    for (int k = 1; k < 4; k++) begin
      step(1'b1, 3'(k), 1'b0);
      check(3'd1, "R9 hold without request");
    end
    step(1'b0, 3'd0, 1'b1);
    check(3'd4, "R6 after accesses");
    step(1'b1, 3'd4, 1'b1);
    check(3'd4, "R10 same-cycle access");
    step(1'b0, 3'd0, 1'b1);
    check(3'd5, "R10 access then applied");

    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(3'd0, "R1 reset mid-run");
    rst = 1'b0;
    step(1'b0, 3'd0, 1'b1);
    check(3'd0, "R1 flags cleared by reset");

    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run incomplete, expected finish");
      summary();
    end
  end
endmodule